// File: doc/BRIEF.md
# Pipelined CORDIC Quadrature NCO

This block is a numerically controlled oscillator that generates the cosine (I) and sine (Q) local-oscillator samples for a digital down-conversion chain, one pair for every accepted input sample. A 24-bit phase accumulator adds the frequency tuning word whenever the input valid is high. The accumulated phase is read as a signed angle in [-π, π) and registered. A second stage folds it into [-π/2, π/2] and remembers whether a half-turn was removed. A fully unrolled chain of shift-add micro-rotations then turns a pre-scaled unit vector by the residual angle.

The CORDIC gain is cancelled up front by starting the vector at full scale divided by the gain, so no multiplier appears anywhere. At the end, both outputs are negated when the fold removed a half-turn, then rounded and saturated to the output width. The block accepts a new sample on every clock and has a fixed latency. A valid bit travels beside the data, and the outputs keep their last value whenever no sample leaves the pipeline.

Top module: `nco_cordic_top`

## Requirements
- R1: After reset, valid_o, cos_o and sin_o are 0, and they stay 0 until the first valid sample leaves the pipeline.
- R2: valid_o in clock cycle c+23 equals valid_i in cycle c: 23 register stages, with no stall and no reordering.
- R3: The accumulator starts at 0 and adds ftw_i modulo 2^24 only in cycles where valid_i is high. The phase of the n-th accepted sample is the sum of the tuning words of samples 0 to n, including its own. ftw_i has no effect while valid_i is low.
- R4: For a sample with phase p (the full 24-bit range spans one turn), cos_o is within ±4 LSB of A·cos(2πp/2^24), where A = 2^(OUT_W-1) - 2 (32766 by default).
- R5: For the same sample, sin_o is within ±4 LSB of A·sin(2πp/2^24).
- R6: R4 and R5 hold in all four quadrants. This includes the exact quarter-turn phases 0, 2^22, 2^23 and 3·2^22, and phases just below the wrap at 2^24.
- R7: While valid_o is low, cos_o and sin_o hold their previous values.
- R8: Back-to-back valid inputs produce back-to-back valid outputs: one sample pair per clock.
- R9: On every valid output, cos_o² + sin_o² lies between (A-6)² and (A+6)².

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe; advances the phase accumulator |
| ftw_i | input | 24 | Frequency tuning word, phase increment per accepted sample |
| valid_o | output | 1 | Output sample strobe |
| cos_o | output | 16 | Signed I local-oscillator sample |
| sin_o | output | 16 | Signed Q local-oscillator sample |

## Verification
Every output sample is due exactly 23 clocks after the cycle in which its valid_i was presented. The bench keeps a history of valid_i indexed by cycle and compares valid_o in each cycle against the entry from 23 cycles earlier. It also keeps a queue of model phases, pushed when an input is accepted and popped when valid_o is high, so each output pair is matched to its own phase even when valid_i has gaps. Inputs change just after the rising edge and outputs are read on the falling edge, so every comparison reads a settled register value.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // product of sqrt(1 + 2^-2i) over all micro-rotations
  function automatic real cordic_gain(int iters);
    real k;
    real p;
    k = 1.0;
    p = 1.0;
    for (int i = 0; i < iters; i++) begin
      k = k * $sqrt(1.0 + p);
      p = p * 0.25;
    end
    return k;
  endfunction

  // start vector: amplitude divided by gain, scaled by fractional bits
  function automatic int x_init(int out_w, int frac_w, int iters);
    real a;
    a = real'((1 << (out_w - 1)) - 2) * real'(1 << frac_w);
    return $rtoi(a / cordic_gain(iters) + 0.5);
  endfunction

  // atan(2^-i) in phase units, where 2^pw units = one turn
  function automatic int atan_units(int i, int pw);
    real t;
    real s;
    t = 1.0;
    s = 1.0;
    for (int j = 0; j < i; j++) t = t * 0.5;
    for (int j = 0; j < pw; j++) s = s * 2.0;
    return $rtoi($atan(t) / TWO_PI * s + 0.5);
  endfunction

endpackage

// File: rtl/nco_phase_front.sv
module nco_phase_front #(
  parameter int PHASE_W = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [PHASE_W-1:0]        ftw_i,
  output logic signed [PHASE_W-1:0] z_o,
  output logic                      flip_o,
  output logic                      valid_o
);

  localparam logic signed [PHASE_W-1:0] QTR  = PHASE_W'(longint'(1) << (PHASE_W - 2));
  localparam logic        [PHASE_W-1:0] HALF = PHASE_W'(longint'(1) << (PHASE_W - 1));

  // stage 0: accumulator, read as signed angle in [-pi, pi)
  logic [PHASE_W-1:0] acc_q;
  logic               v0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      v0_q  <= 1'b0;
    end else begin
      v0_q <= valid_i;
      if (valid_i) acc_q <= acc_q + ftw_i;
    end
  end

  logic signed [PHASE_W-1:0] ph_s;
  logic signed [PHASE_W-1:0] z_d;
  logic                      flip_d;

  assign ph_s = signed'(acc_q);

  // stage 1: fold into [-pi/2, pi/2], a half-turn removed flips output signs
  always_comb begin
    flip_d = (ph_s > QTR) || (ph_s < -QTR);
    z_d    = flip_d ? signed'(acc_q + HALF) : ph_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_o     <= '0;
      flip_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      z_o     <= z_d;
      flip_o  <= flip_d;
      valid_o <= v0_q;
    end
  end

endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage #(
  parameter int                     DW    = 22,
  parameter int                     ZW    = 24,
  parameter int                     SHIFT = 0,
  parameter logic signed [ZW-1:0]   ANG   = '0,
  parameter bit                     REG   = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  logic                 flip_i,
  input  logic                 valid_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output logic                 flip_o,
  output logic                 valid_o
);

  logic                 neg;
  logic signed [DW-1:0] xs;
  logic signed [DW-1:0] ys;
  logic signed [DW-1:0] x_n;
  logic signed [DW-1:0] y_n;
  logic signed [ZW-1:0] z_n;

  // rotate toward zero residual angle
  always_comb begin
    neg = z_i[ZW-1];
    xs  = x_i >>> SHIFT;
    ys  = y_i >>> SHIFT;
    x_n = neg ? x_i + ys  : x_i - ys;
    y_n = neg ? y_i - xs  : y_i + xs;
    z_n = neg ? z_i + ANG : z_i - ANG;
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_o     <= '0;
        y_o     <= '0;
        z_o     <= '0;
        flip_o  <= 1'b0;
        valid_o <= 1'b0;
      end else begin
        x_o     <= x_n;
        y_o     <= y_n;
        z_o     <= z_n;
        flip_o  <= flip_i;
        valid_o <= valid_i;
      end
    end
  end else begin : g_comb
    // last micro-rotation shares the output register
    assign x_o     = x_n;
    assign y_o     = y_n;
    assign z_o     = z_n;
    assign flip_o  = flip_i;
    assign valid_o = valid_i;
  end

endmodule

// File: rtl/nco_out_round.sv
module nco_out_round #(
  parameter int DW     = 22,
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [DW-1:0]    x_i,
  input  logic signed [DW-1:0]    y_i,
  input  logic                    flip_i,
  input  logic                    valid_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic                    valid_o
);

  localparam int EW = DW + 1;
  localparam logic signed [EW-1:0] HALF_LSB = EW'(longint'(1) << (FRAC_W - 1));
  localparam logic signed [EW-1:0] MAX_V    = EW'((longint'(1) << (OUT_W - 1)) - 1);

  function automatic logic signed [OUT_W-1:0] fix(input logic signed [DW-1:0] v, input logic f);
    logic signed [EW-1:0] e;
    logic signed [EW-1:0] r;
    e = f ? -EW'(v) : EW'(v);
    r = (e + HALF_LSB) >>> FRAC_W;
    if (r > MAX_V)       r = MAX_V;
    else if (r < -MAX_V) r = -MAX_V;
    return r[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o   <= '0;
      sin_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        cos_o <= fix(x_i, flip_i);
        sin_o <= fix(y_i, flip_i);
      end
    end
  end

endmodule

// File: rtl/nco_cordic_top.sv
module nco_cordic_top #(
  parameter int PHASE_W = 24,
  parameter int OUT_W   = 16,
  parameter int ITER    = 21,
  parameter int GUARD_W = 2,
  parameter int FRAC_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [PHASE_W-1:0]      ftw_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);

  localparam int DW  = OUT_W + GUARD_W + FRAC_W;
  localparam int ZW  = PHASE_W;
  localparam int LAT = ITER + 2;
  localparam logic signed [DW-1:0] X0 = DW'(nco_pkg::x_init(OUT_W, FRAC_W, ITER));

  logic signed [DW-1:0] x_s [ITER+1];
  logic signed [DW-1:0] y_s [ITER+1];
  logic signed [ZW-1:0] z_s [ITER+1];
  logic                 f_s [ITER+1];
  logic                 v_s [ITER+1];

  nco_phase_front #(.PHASE_W(PHASE_W)) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ftw_i   (ftw_i),
    .z_o     (z_s[0]),
    .flip_o  (f_s[0]),
    .valid_o (v_s[0])
  );

  assign x_s[0] = X0;
  assign y_s[0] = '0;

  for (genvar g = 0; g < ITER; g++) begin : g_rot
    localparam logic signed [ZW-1:0] ANG_G = ZW'(nco_pkg::atan_units(g, PHASE_W));
    nco_cordic_stage #(
      .DW    (DW),
      .ZW    (ZW),
      .SHIFT (g),
      .ANG   (ANG_G),
      .REG   (g < ITER - 1)
    ) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .x_i     (x_s[g]),
      .y_i     (y_s[g]),
      .z_i     (z_s[g]),
      .flip_i  (f_s[g]),
      .valid_i (v_s[g]),
      .x_o     (x_s[g+1]),
      .y_o     (y_s[g+1]),
      .z_o     (z_s[g+1]),
      .flip_o  (f_s[g+1]),
      .valid_o (v_s[g+1])
    );
  end

  nco_out_round #(.DW(DW), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .x_i     (x_s[ITER]),
    .y_i     (y_s[ITER]),
    .flip_i  (f_s[ITER]),
    .valid_i (v_s[ITER]),
    .cos_o   (cos_o),
    .sin_o   (sin_o),
    .valid_o (valid_o)
  );

endmodule

// File: rtl/nco_cordic_chk.sv
module nco_cordic_chk #(
  parameter int OUT_W = 16,
  parameter int LAT   = 23
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] cos_o,
  input logic signed [OUT_W-1:0] sin_o
);

  localparam longint AMP = (longint'(1) << (OUT_W - 1)) - 2;
  localparam longint LO  = (AMP - 6) * (AMP - 6);
  localparam longint HI  = (AMP + 6) * (AMP + 6);

  logic [LAT-1:0] hist_q;
  logic           seen_q;
  longint         mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      seen_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[LAT-2:0], valid_i};
      if (valid_o) seen_q <= 1'b1;
    end
  end

  assign mag = longint'(cos_o) * longint'(cos_o) + longint'(sin_o) * longint'(sin_o);

  // R2
  lat_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == hist_q[LAT-1]);

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !valid_o) |-> (cos_o == '0 && sin_o == '0));

  // R7
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(cos_o) && $stable(sin_o)));

  // R9
  mag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mag >= LO && mag <= HI));

endmodule

bind nco_cordic_top nco_cordic_chk #(.OUT_W(OUT_W), .LAT(LAT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .cos_o   (cos_o),
  .sin_o   (sin_o)
);

// File: tb/tb_nco_cordic_top.sv
module tb_nco_cordic_top;

  localparam int  LAT  = 23;
  localparam real AMP  = 32766.0;
  localparam real TOL  = 4.0;
  localparam real FULL = 16777216.0;
  localparam real TPI  = 6.283185307179586;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic [23:0]        ftw_i = '0;
  logic               valid_o;
  logic signed [15:0] cos_o;
  logic signed [15:0] sin_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nco_cordic_top dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ftw_i   (ftw_i),
    .valid_o (valid_o),
    .cos_o   (cos_o),
    .sin_o   (sin_o)
  );

  // model state
  bit          vhist [64];
  int unsigned phq [1024];
  int          wr = 0;
  int          rd = 0;
  int          ncyc = 0;
  logic [23:0] acc_m = '0;
  bit          seen = 1'b0;
  logic signed [15:0] last_c = '0;
  logic signed [15:0] last_s = '0;

  initial for (int i = 0; i < 64; i++) vhist[i] = 1'b0;

  task automatic cmp_trig(input int unsigned ph);
    real ang;
    real ec;
    real es;
    ang = TPI * real'(ph) / FULL;
    ec  = AMP * $cos(ang);
    es  = AMP * $sin(ang);
    nchk++;
    if (real'(cos_o) - ec > TOL || ec - real'(cos_o) > TOL) begin
      nfail++;
      $display("FAIL R3 R4 R6 cos ph=%06h got %0d exp %0d", ph, cos_o, $rtoi(ec));
    end
    nchk++;
    if (real'(sin_o) - es > TOL || es - real'(sin_o) > TOL) begin
      nfail++;
      $display("FAIL R3 R5 R6 sin ph=%06h got %0d exp %0d", ph, sin_o, $rtoi(es));
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      bit exp_v;
      exp_v = (ncyc >= LAT) ? vhist[(ncyc - LAT) % 64] : 1'b0;
      // R2 R8: valid_o is valid_i from 23 cycles earlier
      nchk++;
      if (valid_o !== exp_v) begin
        nfail++;
        $display("FAIL R2 R8 valid_o cyc=%0d got %0b exp %0b", ncyc, valid_o, exp_v);
      end
      if (valid_o) begin
        cmp_trig(phq[rd % 1024]);
        rd++;
        seen   = 1'b1;
        last_c = cos_o;
        last_s = sin_o;
      end else if (!seen) begin
        nchk++;
        if (cos_o !== 16'sd0 || sin_o !== 16'sd0) begin
          nfail++;
          $display("FAIL R1 idle outputs got %0d/%0d exp 0/0", cos_o, sin_o);
        end
      end else begin
        nchk++;
        if (cos_o !== last_c || sin_o !== last_s) begin
          nfail++;
          $display("FAIL R7 hold got %0d/%0d exp %0d/%0d", cos_o, sin_o, last_c, last_s);
        end
      end
      // R3: accumulate only on accepted samples, phase includes own word
      vhist[ncyc % 64] = valid_i;
      if (valid_i) begin
        acc_m = acc_m + ftw_i;
        phq[wr % 1024] = int'(acc_m);
        wr++;
      end
      ncyc++;
    end
  end

  task automatic drive(input bit v, input logic [23:0] f);
    @(posedge clk);
    #2;
    valid_i = v;
    ftw_i   = f;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while in reset
    nchk++;
    if (valid_o !== 1'b0 || cos_o !== 16'sd0 || sin_o !== 16'sd0) begin
      nfail++;
      $display("FAIL R1 reset got v=%0b c=%0d s=%0d exp 0", valid_o, cos_o, sin_o);
    end
    @(posedge clk);
    #2;
    rst_ni = 1'b1;
    repeat (5) drive(1'b0, 24'h55AA55);
    // R6 R8: 1/64 turn steps, back to back, hits every quarter point
    for (int i = 0; i < 70; i++) drive(1'b1, 24'h040000);
    // R3 R7: gapped input, junk tuning word while idle
    for (int i = 0; i < 150; i++) begin
      if (i % 3 == 1) drive(1'b0, 24'hFFFFFF);
      else            drive(1'b1, 24'h0A3D71);
    end
    repeat (7) drive(1'b0, 24'h123456);
    // R6: small negative step across the wrap
    for (int i = 0; i < 40; i++) drive(1'b1, 24'hFFFF00);
    // R4 R5: half-turn steps
    for (int i = 0; i < 10; i++) drive(1'b1, 24'h800000);
    // R6: odd step, near-quadrant phases
    for (int i = 0; i < 60; i++) drive(1'b1, 24'h3FFFFF);
    repeat (LAT + 10) drive(1'b0, 24'h000000);
    @(negedge clk);
    done = 1'b1;
    nchk++;
    if (rd != wr) begin
      nfail++;
      $display("FAIL R2 sample count got %0d exp %0d", rd, wr);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL R2 watchdog got hung run exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule